// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block sits beside the fetch unit and decides where fetch goes next. Each cycle it takes the current fetch address and searches a 4-way set-associative table of branches that have been seen before. Every entry holds an address tag, a 4-bit record of the branch's most recent outcomes, and the last taken target. When the search finds a matching entry, the block makes a taken/not-taken guess from that record. A taken guess steers fetch to the stored target. A not-taken guess, or a miss, steers fetch to the next sequential instruction word.

When a branch completes in the execute stage, it reports its address, its actual outcome and its target on the resolve port. If the branch is already in the table, its entry is refreshed in place. If it is not, and it resolved taken, a new entry is written into its set. The way that receives it is an empty way if there is one. Otherwise a pseudo-LRU tree, kept per set, picks the way.

Top module: `btb_predictor`

## Requirements
- R1: After reset every lookup misses, so `pred_hit` and `pred_taken` are 0 and `pred_next_addr` equals `fetch_addr + 4`.
- R2: The set is chosen by address bits [8:2] and the tag is bits [31:9]. Address bits [1:0] take no part in the match, so two addresses that differ only in those bits hit the same entry. An address in the same set with a different tag misses.
- R3: On a miss, and whenever `fetch_valid` is 0, `pred_hit` and `pred_taken` are 0 and `pred_next_addr` is `fetch_addr + 4`.
- R4: A taken resolve of a branch that is not in the table allocates an entry. The entry's history is set to 4'b1111 and its target to `res_target`. A later lookup of that address hits, predicts taken, and returns that target.
- R5: A not-taken resolve of a branch that is not in the table writes nothing. A later lookup of that address still misses.
- R6: A resolve that hits shifts the outcome into the history, with the newest outcome at bit 0 and 1 meaning taken, so N,T,N,T gives 4'b0101. The stored target is replaced only when the outcome is taken. A not-taken outcome keeps the old target.
- R7: A hit predicts taken exactly when at least two of history bits [2:0] are 1. A hit that predicts not taken gives `fetch_addr + 4`.
- R8: A new entry goes to the lowest-numbered empty way of its set. When the set is full, the victim is picked from a 3-bit tree:
  - Bit 0 chooses between the pairs: 0 selects ways 0/1 and 1 selects ways 2/3.
  - Bit 1 chooses within the first pair: 0 selects way 0.
  - Bit 2 chooses within the second pair: 0 selects way 2.
  - Every allocation or refresh of a way sets the bits on its path to point away from it.
  - Trees reset to 0.
- R9: When a lookup and a resolve touch the same set in one cycle, the lookup returns the contents from before the write. The write is visible from the next cycle on.
- R10: A branch occupies at most one way of a set. A taken resolve of a branch that is already present refreshes that entry and leaves the other ways of the set unchanged.
- R11: With `fetch_valid` at 0, no hit is reported, even for an address that is in the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A lookup is requested this cycle |
| fetch_addr | input | 32 | Current fetch address |
| pred_hit | output | 1 | Lookup matched an entry |
| pred_taken | output | 1 | Matched entry predicts taken |
| pred_next_addr | output | 32 | Predicted next fetch address |
| res_valid | input | 1 | A resolved branch is reported |
| res_addr | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome, 1 means taken |
| res_target | input | 32 | Actual target of the resolved branch |

## Verification
Outputs are combinational over the table. A corrupted tag, valid bit, history or target therefore shows up on `pred_hit`, `pred_taken` or `pred_next_addr` the first time that set is looked up after the bad write. That can happen as early as the cycle after the resolve. A bad replacement-tree state stays hidden until a full set takes a new branch. It then appears as the wrong surviving branch missing on its next lookup. For that reason the stimulus crowds six tags into a few sets and compares every cycle against an independent model.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int BTB_ADDR_W     = 32;
    localparam int BTB_SETS       = 128;
    localparam int BTB_WAYS       = 4;
    localparam int BTB_HIST_W     = 4;
    localparam int BTB_INST_BYTES = 4;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_REFRESH,
        WR_INSERT
    } wr_kind_e;

    // Majority vote over the three newest outcomes.
    function automatic logic vote_taken(input logic [2:0] last3);
        return (last3[0] & last3[1]) | (last3[0] & last3[2]) | (last3[1] & last3[2]);
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int ADDR_W = BTB_ADDR_W,
    parameter int SETS   = BTB_SETS,
    parameter int WAYS   = BTB_WAYS,
    parameter int HIST_W = BTB_HIST_W
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [$clog2(SETS)-1:0]            a_set,
    output logic [WAYS-1:0]                    a_valid,
    output logic [WAYS-1:0][ADDR_W-$clog2(SETS)-3:0] a_tag,
    output logic [WAYS-1:0][HIST_W-1:0]        a_hist,
    output logic [WAYS-1:0][ADDR_W-1:0]        a_tgt,
    input  logic [$clog2(SETS)-1:0]            b_set,
    output logic [WAYS-1:0]                    b_valid,
    output logic [WAYS-1:0][ADDR_W-$clog2(SETS)-3:0] b_tag,
    input  wr_kind_e                           wr_kind,
    input  logic [$clog2(SETS)-1:0]            wr_set,
    input  logic [$clog2(WAYS)-1:0]            wr_way,
    input  logic [ADDR_W-$clog2(SETS)-3:0]     wr_tag,
    input  logic                               wr_taken,
    input  logic [ADDR_W-1:0]                  wr_target
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - 2;
    localparam int WAY_W = $clog2(WAYS);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]   vld_q;
        logic [TAG_W-1:0]  tag_q  [SETS];
        logic [HIST_W-1:0] hist_q [SETS];
        logic [ADDR_W-1:0] tgt_q  [SETS];
        logic              sel;

        assign sel = (wr_way == WAY_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
            end else if (wr_kind == WR_INSERT && sel) begin
                vld_q[wr_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                if (wr_kind == WR_INSERT) begin
                    tag_q[wr_set]  <= wr_tag;
                    hist_q[wr_set] <= '1;
                    tgt_q[wr_set]  <= wr_target;
                end else if (wr_kind == WR_REFRESH) begin
                    hist_q[wr_set] <= {hist_q[wr_set][HIST_W-2:0], wr_taken};
                    if (wr_taken) begin
                        tgt_q[wr_set] <= wr_target;
                    end
                end
            end
        end

        assign a_valid[w] = vld_q[a_set];
        assign a_tag[w]   = tag_q[a_set];
        assign a_hist[w]  = hist_q[a_set];
        assign a_tgt[w]   = tgt_q[a_set];
        assign b_valid[w] = vld_q[b_set];
        assign b_tag[w]   = tag_q[b_set];
    end

endmodule

// File: rtl/btb_match.sv
module btb_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 23
) (
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            key,
    output logic [WAYS-1:0]             vec,
    output logic                        hit,
    output logic [$clog2(WAYS)-1:0]     way
);
    localparam int WAY_W = $clog2(WAYS);

    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int w = 0; w < WAYS; w++) begin
            vec[w] = valid[w] && (tags[w] == key);
        end
        for (int w = 0; w < WAYS; w++) begin
            if (vec[w] && !hit) begin
                hit = 1'b1;
                way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/btb_plru.sv
module btb_plru #(
    parameter int SETS = 128,
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(SETS)-1:0]  rd_set,
    output logic [$clog2(WAYS)-1:0]  victim,
    input  logic                     touch_en,
    input  logic [$clog2(SETS)-1:0]  touch_set,
    input  logic [$clog2(WAYS)-1:0]  touch_way
);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int NODE_N = WAYS - 1;

    logic [NODE_N-1:0] tree_q [SETS];

    // Walk from the root, each node bit pointing to the colder half.
    function automatic logic [WAY_W-1:0] pick(input logic [NODE_N-1:0] t);
        int n;
        n = 0;
        for (int l = 0; l < WAY_W; l++) begin
            n = 2 * n + 1 + int'(t[n]);
        end
        return WAY_W'(n - NODE_N);
    endfunction

    // Point every node on the used way's path away from it.
    function automatic logic [NODE_N-1:0] mark(input logic [NODE_N-1:0] t,
                                               input logic [WAY_W-1:0]  w);
        logic [NODE_N-1:0] r;
        int   n;
        logic b;
        r = t;
        n = 0;
        for (int l = 0; l < WAY_W; l++) begin
            b    = w[WAY_W-1-l];
            r[n] = ~b;
            n    = 2 * n + 1 + int'(b);
        end
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                tree_q[s] <= '0;
            end
        end else if (touch_en) begin
            tree_q[touch_set] <= mark(tree_q[touch_set], touch_way);
        end
    end

    assign victim = pick(tree_q[rd_set]);

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W = BTB_ADDR_W,
    parameter int SETS   = BTB_SETS,
    parameter int WAYS   = BTB_WAYS,
    parameter int HIST_W = BTB_HIST_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_next_addr,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_addr,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - 2;
    localparam int WAY_W = $clog2(WAYS);

    // Address split
    logic [IDX_W-1:0] lk_set, rs_set;
    logic [TAG_W-1:0] lk_tag, rs_tag;

    assign lk_set = fetch_addr[IDX_W+1:2];
    assign lk_tag = fetch_addr[ADDR_W-1:IDX_W+2];
    assign rs_set = res_addr[IDX_W+1:2];
    assign rs_tag = res_addr[ADDR_W-1:IDX_W+2];

    // Table read ports
    logic [WAYS-1:0]             lk_valid, rs_valid;
    logic [WAYS-1:0][TAG_W-1:0]  lk_tags, rs_tags;
    logic [WAYS-1:0][HIST_W-1:0] lk_hists;
    logic [WAYS-1:0][ADDR_W-1:0] lk_tgts;

    // Write command
    wr_kind_e         wr_kind;
    logic [WAY_W-1:0] wr_way;

    btb_store #(
        .ADDR_W (ADDR_W),
        .SETS   (SETS),
        .WAYS   (WAYS),
        .HIST_W (HIST_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .a_set     (lk_set),
        .a_valid   (lk_valid),
        .a_tag     (lk_tags),
        .a_hist    (lk_hists),
        .a_tgt     (lk_tgts),
        .b_set     (rs_set),
        .b_valid   (rs_valid),
        .b_tag     (rs_tags),
        .wr_kind   (wr_kind),
        .wr_set    (rs_set),
        .wr_way    (wr_way),
        .wr_tag    (rs_tag),
        .wr_taken  (res_taken),
        .wr_target (res_target)
    );

    // Tag compare, one matcher per port
    logic [WAYS-1:0]  lk_vec, rs_vec;
    logic             lk_hit, rs_hit;
    logic [WAY_W-1:0] lk_way, rs_way;

    btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .valid (lk_valid),
        .tags  (lk_tags),
        .key   (lk_tag),
        .vec   (lk_vec),
        .hit   (lk_hit),
        .way   (lk_way)
    );

    btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_rs_match (
        .valid (rs_valid),
        .tags  (rs_tags),
        .key   (rs_tag),
        .vec   (rs_vec),
        .hit   (rs_hit),
        .way   (rs_way)
    );

    // Replacement
    logic [WAY_W-1:0] tree_victim, alloc_way;
    logic             free_found;

    btb_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk       (clk),
        .rst       (rst),
        .rd_set    (rs_set),
        .victim    (tree_victim),
        .touch_en  (wr_kind != WR_IDLE),
        .touch_set (rs_set),
        .touch_way (wr_way)
    );

    always_comb begin
        free_found = 1'b0;
        alloc_way  = tree_victim;
        for (int w = 0; w < WAYS; w++) begin
            if (!rs_valid[w] && !free_found) begin
                free_found = 1'b1;
                alloc_way  = WAY_W'(w);
            end
        end
    end

    always_comb begin
        wr_kind = WR_IDLE;
        if (res_valid) begin
            if (rs_hit) begin
                wr_kind = WR_REFRESH;
            end else if (res_taken) begin
                wr_kind = WR_INSERT;
            end
        end
    end

    assign wr_way = rs_hit ? rs_way : alloc_way;

    // Prediction
    logic [HIST_W-1:0] sel_hist;
    logic [ADDR_W-1:0] sel_tgt, seq_addr;

    assign sel_hist       = lk_hists[lk_way];
    assign sel_tgt        = lk_tgts[lk_way];
    assign seq_addr       = fetch_addr + ADDR_W'(BTB_INST_BYTES);
    assign pred_hit       = fetch_valid && lk_hit;
    assign pred_taken     = pred_hit && vote_taken(sel_hist[2:0]);
    assign pred_next_addr = pred_taken ? sel_tgt : seq_addr;

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              pred_hit,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_next_addr,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_addr,
    input logic              res_taken,
    input logic [ADDR_W-1:0] res_target,
    input logic              rs_hit,
    input logic [WAYS-1:0]   lk_vec,
    input logic [WAYS-1:0]   rs_vec
);
    AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> !pred_hit) // R1
        else $error("reset left a live entry");
    AST_TAKEN_HAS_HIT: assert property (@(posedge clk) disable iff (rst) pred_taken |-> pred_hit) // R3
        else $error("taken without hit");
    AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (rst)
        !pred_taken |-> pred_next_addr == fetch_addr + ADDR_W'(4)) // R7
        else $error("non-taken path not sequential");
    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst) !fetch_valid |-> !pred_hit) // R11
        else $error("hit without fetch");
    AST_ALLOC_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_taken && !rs_hit) |=>
        (!(fetch_valid && fetch_addr == $past(res_addr)) ||
         (pred_hit && pred_taken && pred_next_addr == $past(res_target)))) // R4
        else $error("new entry not predicted taken");
    AST_NT_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_taken && !rs_hit) |=>
        !(fetch_valid && fetch_addr == $past(res_addr) && pred_hit)) // R5
        else $error("not-taken miss was allocated");
    AST_SINGLE_COPY_LK: assert property (@(posedge clk) disable iff (rst) $onehot0(lk_vec)) // R10
        else $error("duplicate tag in lookup set");
    AST_SINGLE_COPY_RS: assert property (@(posedge clk) disable iff (rst) $onehot0(rs_vec)) // R10
        else $error("duplicate tag in resolve set");
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .fetch_valid    (fetch_valid),
    .fetch_addr     (fetch_addr),
    .pred_hit       (pred_hit),
    .pred_taken     (pred_taken),
    .pred_next_addr (pred_next_addr),
    .res_valid      (res_valid),
    .res_addr       (res_addr),
    .res_taken      (res_taken),
    .res_target     (res_target),
    .rs_hit         (rs_hit),
    .lk_vec         (lk_vec),
    .rs_vec         (rs_vec)
);

// File: tb/btb_predictor_tb_top.sv
`timescale 1ns/1ps
module btb_predictor_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        pred_hit, pred_taken;
    logic [31:0] pred_next_addr;
    logic        res_valid = 1'b0;
    logic [31:0] res_addr = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    btb_predictor dut_i (
        .clk            (clk),
        .rst            (rst),
        .fetch_valid    (fetch_valid),
        .fetch_addr     (fetch_addr),
        .pred_hit       (pred_hit),
        .pred_taken     (pred_taken),
        .pred_next_addr (pred_next_addr),
        .res_valid      (res_valid),
        .res_addr       (res_addr),
        .res_taken      (res_taken),
        .res_target     (res_target)
    );

    // Reference model built from the requirements
    bit          m_valid [128][4];
    logic [22:0] m_tag   [128][4];
    logic [3:0]  m_hist  [128][4];
    logic [31:0] m_tgt   [128][4];
    logic [2:0]  m_tree  [128];

    function automatic void model_clear();
        for (int s = 0; s < 128; s++) begin
            m_tree[s] = '0;
            for (int w = 0; w < 4; w++) m_valid[s][w] = 1'b0;
        end
    endfunction

    function automatic int tree_victim(logic [2:0] t);
        if (!t[0]) return t[1] ? 1 : 0;
        return t[2] ? 3 : 2;
    endfunction

    function automatic logic [2:0] tree_touch(logic [2:0] t, int w);
        logic [2:0] r = t;
        case (w)
            0: begin r[0] = 1'b1; r[1] = 1'b1; end
            1: begin r[0] = 1'b1; r[1] = 1'b0; end
            2: begin r[0] = 1'b0; r[2] = 1'b1; end
            default: begin r[0] = 1'b0; r[2] = 1'b0; end
        endcase
        return r;
    endfunction

    function automatic int find_way(logic [31:0] a);
        for (int w = 0; w < 4; w++)
            if (m_valid[a[8:2]][w] && m_tag[a[8:2]][w] == a[31:9]) return w;
        return -1;
    endfunction

    function automatic void model_resolve(logic [31:0] a, bit tk, logic [31:0] tg);
        int s = int'(a[8:2]);
        int w = find_way(a);
        if (w >= 0) begin
            m_hist[s][w] = {m_hist[s][w][2:0], tk};
            if (tk) m_tgt[s][w] = tg;
            m_tree[s] = tree_touch(m_tree[s], w);
        end else if (tk) begin
            w = -1;
            for (int i = 0; i < 4; i++) if (!m_valid[s][i] && w < 0) w = i;
            if (w < 0) w = tree_victim(m_tree[s]);
            m_valid[s][w] = 1'b1;
            m_tag[s][w]   = a[31:9];
            m_hist[s][w]  = 4'b1111;
            m_tgt[s][w]   = tg;
            m_tree[s] = tree_touch(m_tree[s], w);
        end
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: drive, compare against the pre-write model, then apply the write.
    task automatic step(string req, bit fv, logic [31:0] fa,
                        bit rv, logic [31:0] ra, bit rt, logic [31:0] rg);
        bit e_hit, e_tk;
        logic [31:0] e_next;
        int w;
        @(negedge clk);
        fetch_valid = fv; fetch_addr = fa;
        res_valid = rv; res_addr = ra; res_taken = rt; res_target = rg;
        #1;
        w = find_way(fa);
        e_hit = fv && (w >= 0);
        e_tk = 1'b0;
        e_next = fa + 32'd4;
        if (e_hit) begin
            logic [3:0] h = m_hist[fa[8:2]][w];
            e_tk = (int'(h[0]) + int'(h[1]) + int'(h[2])) >= 2;
            if (e_tk) e_next = m_tgt[fa[8:2]][w];
        end
        check(req, "hit", {31'b0, pred_hit}, {31'b0, e_hit});
        check(req, "taken", {31'b0, pred_taken}, {31'b0, e_tk});
        check(req, "next", pred_next_addr, e_next);
        if (rv) model_resolve(ra, rt, rg);
    endtask

    function automatic logic [31:0] rnd_addr();
        logic [31:0] t = 32'($urandom % 6);
        logic [31:0] s = ($urandom % 2) ? 32'd3 : 32'd17;
        return 32'h4000_0000 | (t << 9) | (s << 2);
    endfunction

    initial begin
        logic [31:0] a, b, c;
        logic [31:0] f [5];
        void'($urandom(32'd20240611));
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        a = 32'h0000_1a40;
        b = 32'h0000_2b80;
        step("R1", 1, a, 0, 0, 0, 0);
        // R5: not-taken miss allocates nothing
        step("R5", 1, a, 1, a, 0, 32'h0000_9000);
        step("R5", 1, a, 0, 0, 0, 0);
        // R9: same-set lookup sees old contents, then new entry next cycle
        step("R9", 1, b, 1, b, 1, 32'h0000_7700);
        step("R9", 1, b, 0, 0, 0, 0);
        // R4: allocation
        step("R4", 1, b, 1, a, 1, 32'h0000_5000);
        step("R4", 1, a, 0, 0, 0, 0);
        // R2: low bits ignored, other tag in same set misses
        step("R2", 1, a | 32'h2, 0, 0, 0, 0);
        step("R2", 1, a + 32'h200, 0, 0, 0, 0);
        // R6 and R7: history walk
        step("R7", 1, a, 1, a, 0, 32'h0000_6000);
        step("R7", 1, a, 1, a, 0, 32'h0000_6000);
        step("R7", 1, a, 1, a, 1, 32'h0000_6100);
        step("R6", 1, a, 1, a, 1, 32'h0000_6100);
        step("R6", 1, a, 1, a, 0, 32'h0000_6f00);
        step("R6", 1, a, 0, 0, 0, 0);
        // R11: no hit without fetch_valid
        step("R11", 0, a, 0, 0, 0, 0);
        // R8: fill set 9 then force a replacement
        for (int i = 0; i < 5; i++) f[i] = 32'h0001_0000 + (32'(i) << 9) + (32'd9 << 2);
        for (int i = 0; i < 5; i++) step("R8", 0, 0, 1, f[i], 1, 32'h0000_8000 + 32'(i) * 16);
        for (int i = 0; i < 5; i++) step("R8", 1, f[i], 0, 0, 0, 0);
        // R10: repeated taken resolve of a present branch refreshes in place
        c = f[2];
        for (int i = 0; i < 4; i++) step("R10", 0, 0, 1, c, 1, 32'h0000_a000 + 32'(i) * 8);
        for (int i = 0; i < 5; i++) step("R10", 1, f[i], 0, 0, 0, 0);

        // Random traffic crowding two sets
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] fa = rnd_addr();
            bit fv = ($urandom % 8) != 0;
            bit rv = ($urandom % 10) < 6;
            bit rt = ($urandom % 10) < 6;
            logic [31:0] ra = rnd_addr();
            logic [31:0] rg = $urandom & 32'hffff_fffc;
            string req;
            int w = find_way(fa);
            req = (fv && w >= 0) ? "R7" : "R3";
            step(req, fv, fa, rv, ra, rt, rg);
        end

        @(negedge clk);
        res_valid = 1'b0;
        fetch_valid = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc >= 100000 && !done) begin
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

endmodule